// File: doc/BRIEF.md
# Link Bring-Up Retry Sequencer

This block brings a serial-link root port into operation without software help. After a start pulse it walks through a fixed reset order: PHY reset is pulsed, then a PLL settle delay runs. Core reset is released next, then endpoint reset, and then link training is enabled. It then polls four status inputs. These are a retrain-pending flag, PHY link up, data-link-layer up and data-link-layer active.

An attempt can fail in two ways: PHY link up never appears, or the data-link pair is not both true once the PHY link is up. A failed attempt restarts the whole reset order. After a bounded number of failed attempts the block stops and reports failure. On success it picks a replay timer limit from the negotiated link width and holds it.

All delays count a one-cycle microsecond tick input, so the block runs from any clock frequency. Every delay, poll count and the retry bound is a parameter.

Top module: `link_bringup_seq`

## Requirements
- R1: While and after reset, before any start, phy_rst, core_rst and ep_rst are 1, train_en, done and fail are 0, attempt is 0 and replay_limit is 0.
- R2: Each attempt drives all three resets high for one cycle. Then phy_rst drops, and core_rst stays high until SETTLE_US ticks have been counted. ep_rst drops one cycle after core_rst. At all times a reset is released only when the resets earlier in that order are already released.
- R3: train_en rises one cycle after ep_rst drops. retrain_pending is sampled in the first cycle of training and then after every RT_GAP_US ticks. A low sample moves on to the PHY wait. After RT_POLLS high samples the block moves on anyway, without failing the attempt.
- R4: phy_link_up is sampled on entry to the PHY wait and then after every PHY_GAP_US ticks. If PHY_POLLS samples are all low, the attempt fails.
- R5: One cycle after phy_link_up is seen, dl_up and dl_active must both be 1 for the attempt to succeed. Otherwise the attempt fails.
- R6: A failed attempt restarts from the PHY reset step and raises attempt by one. The first attempt is numbered 1. If attempt MAX_TRIES fails, fail is set and held with phy_rst at 1 and train_en at 0.
- R7: On success, replay_limit takes a value from the 6-bit width code link_width: code 1 (x1) gives 1677, code 2 (x2) gives 867, code 4 (x4) gives 462, code 8 (x8) gives 258, and any other code gives 1677. The value stays stable while done is 1, even if link_width changes.
- R8: done and fail are never 1 together. A start while idle, done or failed clears both and begins attempt 1. A start while a sequence is running has no effect.
- R9: When us_tick is low, no timed step advances. With no ticks, core_rst stays high indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up sequence |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| retrain_pending | input | 1 | Link retrain still pending |
| phy_link_up | input | 1 | PHY reports link up |
| dl_up | input | 1 | Data link layer up |
| dl_active | input | 1 | Data link layer active |
| link_width | input | 6 | Negotiated link width code |
| phy_rst | output | 1 | PHY reset, active high |
| core_rst | output | 1 | Core reset, active high |
| ep_rst | output | 1 | Endpoint reset, active high |
| train_en | output | 1 | Link training enable |
| done | output | 1 | Bring-up succeeded (sticky) |
| fail | output | 1 | All attempts failed (sticky) |
| replay_limit | output | 11 | Replay timer limit chosen on success |
| attempt | output | clog2(MAX_TRIES+1) | Current or last attempt number |

## Verification
The assertions assume that link_width is a plain 6-bit code and that start may arrive in any state. They also assume the status inputs change only between clock edges and follow no protocol. The stimulus therefore drives every input at the falling edge. It holds each status input at a level per scenario, or changes it in response to the observed attempt number.

The tick is driven in three patterns: every cycle, one cycle in three, and not at all. This stretches the timed windows without ever breaking the assumed one-cycle tick shape. A behavioural model predicts every output on every clock. It is checked against explicit end-of-scenario values.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PHY_RST, ST_SETTLE, ST_CORE_REL, ST_EP_REL,
    ST_RETRAIN, ST_PHY_WAIT, ST_DL_CHECK, ST_DONE, ST_FAIL
  } lbr_state_t;

  localparam int RPL_W = 11;
  localparam int LW_W  = 6;

  // negotiated width codes
  localparam logic [LW_W-1:0] LW_X1 = 6'd1;
  localparam logic [LW_W-1:0] LW_X2 = 6'd2;
  localparam logic [LW_W-1:0] LW_X4 = 6'd4;
  localparam logic [LW_W-1:0] LW_X8 = 6'd8;
endpackage

// File: rtl/lbr_replay_sel.sv
module lbr_replay_sel
  import lbr_pkg::*;
(
  input  logic [LW_W-1:0]  lane_code,
  output logic [RPL_W-1:0] limit
);
  always_comb begin
    case (lane_code)
      LW_X2:   limit = 11'd867;
      LW_X4:   limit = 11'd462;
      LW_X8:   limit = 11'd258;
      LW_X1:   limit = 11'd1677;
      default: limit = 11'd1677;
    endcase
  end
endmodule

// File: rtl/lbr_us_timer.sv
module lbr_us_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          us_tick,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  logic [CW-1:0] cnt;

  assign hit = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt <= '0;
    else if (us_tick && !hit)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import lbr_pkg::*;
#(
  parameter int SETTLE_US  = 20,
  parameter int RT_POLLS   = 10,
  parameter int RT_GAP_US  = 10,
  parameter int PHY_POLLS  = 1000,
  parameter int PHY_GAP_US = 100,
  parameter int MAX_TRIES  = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic                             us_tick,
  input  logic                             retrain_pending,
  input  logic                             phy_link_up,
  input  logic                             dl_up,
  input  logic                             dl_active,
  input  logic [5:0]                       link_width,
  output logic                             phy_rst,
  output logic                             core_rst,
  output logic                             ep_rst,
  output logic                             train_en,
  output logic                             done,
  output logic                             fail,
  output logic [10:0]                      replay_limit,
  output logic [$clog2(MAX_TRIES+1)-1:0]   attempt
);
  localparam int GAP_MAX = (RT_GAP_US > PHY_GAP_US) ? RT_GAP_US : PHY_GAP_US;
  localparam int TMAX    = (SETTLE_US > GAP_MAX) ? SETTLE_US : GAP_MAX;
  localparam int TW      = $clog2(TMAX + 1);
  localparam int PMAX    = (RT_POLLS > PHY_POLLS) ? RT_POLLS : PHY_POLLS;
  localparam int PW      = $clog2(PMAX + 1);
  localparam int AW      = $clog2(MAX_TRIES + 1);

  lbr_state_t state, state_n;
  logic          first;
  logic [PW-1:0] pcnt;
  logic [TW-1:0] tlim;
  logic          thit, trestart;
  logic          poll_now, poll_miss, retry, start_ok, moving;
  logic [RPL_W-1:0] rpl_sel;

  lbr_us_timer #(.CW(TW)) u_timer (
    .clk(clk), .rst(rst), .restart(trestart), .us_tick(us_tick),
    .limit(tlim), .hit(thit)
  );

  lbr_replay_sel u_rpl (.lane_code(link_width), .limit(rpl_sel));

  always_comb begin
    case (state)
      ST_SETTLE:  tlim = TW'(SETTLE_US);
      ST_RETRAIN: tlim = TW'(RT_GAP_US);
      default:    tlim = TW'(PHY_GAP_US);
    endcase
  end

  assign start_ok = start && (state == ST_IDLE || state == ST_DONE || state == ST_FAIL);
  assign poll_now = first || thit;

  always_comb begin
    state_n   = state;
    poll_miss = 1'b0;
    retry     = 1'b0;
    case (state)
      ST_IDLE, ST_DONE, ST_FAIL: if (start) state_n = ST_PHY_RST;
      ST_PHY_RST:  state_n = ST_SETTLE;
      ST_SETTLE:   if (thit) state_n = ST_CORE_REL;
      ST_CORE_REL: state_n = ST_EP_REL;
      ST_EP_REL:   state_n = ST_RETRAIN;
      ST_RETRAIN: begin
        if (poll_now) begin
          // an expired retrain wait is tolerated
          if (!retrain_pending || pcnt == PW'(RT_POLLS - 1)) state_n = ST_PHY_WAIT;
          else poll_miss = 1'b1;
        end
      end
      ST_PHY_WAIT: begin
        if (poll_now) begin
          if (phy_link_up)                        state_n = ST_DL_CHECK;
          else if (pcnt == PW'(PHY_POLLS - 1))    retry   = 1'b1;
          else                                    poll_miss = 1'b1;
        end
      end
      ST_DL_CHECK: begin
        if (dl_up && dl_active) state_n = ST_DONE;
        else                    retry   = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
    if (retry) state_n = (attempt == AW'(MAX_TRIES)) ? ST_FAIL : ST_PHY_RST;
  end

  assign moving   = (state_n != state);
  assign trestart = moving || poll_miss;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      first        <= 1'b0;
      pcnt         <= '0;
      attempt      <= '0;
      replay_limit <= '0;
      phy_rst      <= 1'b1;
      core_rst     <= 1'b1;
      ep_rst       <= 1'b1;
      train_en     <= 1'b0;
      done         <= 1'b0;
      fail         <= 1'b0;
    end else begin
      state <= state_n;
      first <= moving;
      if (moving)         pcnt <= '0;
      else if (poll_miss) pcnt <= pcnt + 1'b1;

      if (start_ok)
        attempt <= AW'(1);
      else if (retry && attempt != AW'(MAX_TRIES))
        attempt <= attempt + 1'b1;

      if (start_ok)
        replay_limit <= '0;
      else if (state == ST_DL_CHECK && state_n == ST_DONE)
        replay_limit <= rpl_sel;

      phy_rst  <= state_n inside {ST_IDLE, ST_PHY_RST, ST_FAIL};
      core_rst <= state_n inside {ST_IDLE, ST_PHY_RST, ST_SETTLE, ST_FAIL};
      ep_rst   <= state_n inside {ST_IDLE, ST_PHY_RST, ST_SETTLE, ST_CORE_REL, ST_FAIL};
      train_en <= state_n inside {ST_RETRAIN, ST_PHY_WAIT, ST_DL_CHECK, ST_DONE};
      done     <= (state_n == ST_DONE);
      fail     <= (state_n == ST_FAIL);
    end
  end
endmodule

// File: rtl/lbr_seq_checker.sv
module lbr_seq_checker #(
  parameter int MAX_TRIES = 5,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          dl_up,
  input logic          dl_active,
  input logic          phy_rst,
  input logic          core_rst,
  input logic          ep_rst,
  input logic          train_en,
  input logic          done,
  input logic          fail,
  input logic [10:0]   replay_limit,
  input logic [AW-1:0] attempt
);
  assert_excl_R8: assert property (@(posedge clk) disable iff (rst) !(done && fail));

  assert_replay_hold_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done || $stable(replay_limit)));

  assert_train_order_R2: assert property (@(posedge clk) disable iff (rst)
    train_en |-> (!ep_rst && !core_rst && !phy_rst));

  assert_ep_order_R2: assert property (@(posedge clk) disable iff (rst)
    !ep_rst |-> !core_rst);

  assert_core_order_R2: assert property (@(posedge clk) disable iff (rst)
    !core_rst |-> !phy_rst);

  assert_attempt_step_R6: assert property (@(posedge clk) disable iff (rst)
    (attempt != $past(attempt)) |-> (attempt == AW'(1) || attempt == $past(attempt) + AW'(1)));

  assert_fail_at_limit_R6: assert property (@(posedge clk) disable iff (rst)
    fail |-> (attempt == AW'(MAX_TRIES)));

  assert_done_link_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(dl_up && dl_active));
endmodule

bind link_bringup_seq lbr_seq_checker #(.MAX_TRIES(MAX_TRIES), .AW($clog2(MAX_TRIES+1))) u_chk (
  .clk(clk), .rst(rst), .dl_up(dl_up), .dl_active(dl_active),
  .phy_rst(phy_rst), .core_rst(core_rst), .ep_rst(ep_rst), .train_en(train_en),
  .done(done), .fail(fail), .replay_limit(replay_limit), .attempt(attempt)
);

// File: tb/link_bringup_seq_bench.sv
module link_bringup_seq_bench;
  localparam int P_SETTLE = 4;
  localparam int P_RTP    = 3;
  localparam int P_RTG    = 2;
  localparam int P_PHP    = 4;
  localparam int P_PHG    = 3;
  localparam int P_TRIES  = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, start = 1'b0, us_tick = 1'b0;
  logic retrain_pending = 1'b0, phy_link_up = 1'b0, dl_up = 1'b0, dl_active = 1'b0;
  logic [5:0] link_width = 6'd1;
  logic phy_rst, core_rst, ep_rst, train_en, done, fail;
  logic [10:0] replay_limit;
  logic [1:0]  attempt;

  int checks = 0, errors = 0;
  int tick_mode = 0, tick_ph = 0;
  bit model_on = 0;
  int e_phy = 1, e_core = 1, e_ep = 1, e_train = 0, e_done = 0, e_fail = 0, e_att = 0, e_rpl = 0;

  link_bringup_seq #(
    .SETTLE_US(P_SETTLE), .RT_POLLS(P_RTP), .RT_GAP_US(P_RTG),
    .PHY_POLLS(P_PHP), .PHY_GAP_US(P_PHG), .MAX_TRIES(P_TRIES)
  ) u_link_bringup_seq (
    .clk(clk), .rst(rst), .start(start), .us_tick(us_tick),
    .retrain_pending(retrain_pending), .phy_link_up(phy_link_up),
    .dl_up(dl_up), .dl_active(dl_active), .link_width(link_width),
    .phy_rst(phy_rst), .core_rst(core_rst), .ep_rst(ep_rst), .train_en(train_en),
    .done(done), .fail(fail), .replay_limit(replay_limit), .attempt(attempt)
  );

  always @(negedge clk) begin
    tick_ph = (tick_ph + 1) % 3;
    case (tick_mode)
      0:       us_tick = 1'b1;
      1:       us_tick = (tick_ph == 0);
      default: us_tick = 1'b0;
    endcase
  end

  function automatic int ref_replay(input logic [5:0] w);
    if (w == 6'd2) return 867;
    if (w == 6'd4) return 462;
    if (w == 6'd8) return 258;
    return 1677;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---- behavioural reference: a sequential timeline per attempt ----
  task automatic model_gap(input int lim);
    int n = 0;
    forever begin
      @(posedge clk);
      if (n == lim) break;
      if (us_tick) n++;
    end
  endtask

  task automatic model_poll(input int which, input int maxp, input int gap, output bit ok);
    int p = 0;
    ok = 0;
    @(posedge clk);
    forever begin
      bit c;
      c = (which == 0) ? !retrain_pending : phy_link_up;
      if (c) begin ok = 1; break; end
      p++;
      if (p == maxp) begin ok = 0; break; end
      model_gap(gap);
    end
  endtask

  initial begin
    wait (!rst);
    model_on = 1;
    forever begin
      do @(posedge clk); while (!start);
      e_done = 0; e_fail = 0; e_rpl = 0;
      for (int a = 1; a <= P_TRIES; a++) begin
        bit ok;
        e_att = a; e_phy = 1; e_core = 1; e_ep = 1; e_train = 0;
        @(posedge clk); e_phy = 0;
        model_gap(P_SETTLE); e_core = 0;
        @(posedge clk); e_ep = 0;
        @(posedge clk); e_train = 1;
        model_poll(0, P_RTP, P_RTG, ok);
        model_poll(1, P_PHP, P_PHG, ok);
        if (ok) begin
          @(posedge clk);
          if (dl_up && dl_active) begin
            e_done = 1; e_rpl = ref_replay(link_width);
            break;
          end
        end
        if (a == P_TRIES) begin
          e_fail = 1; e_phy = 1; e_core = 1; e_ep = 1; e_train = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && model_on) begin
      chk("R2 phy_rst",      int'(phy_rst),      e_phy);
      chk("R2 core_rst",     int'(core_rst),     e_core);
      chk("R2 ep_rst",       int'(ep_rst),       e_ep);
      chk("R3 train_en",     int'(train_en),     e_train);
      chk("R8 done",         int'(done),         e_done);
      chk("R8 fail",         int'(fail),         e_fail);
      chk("R6 attempt",      int'(attempt),      e_att);
      chk("R7 replay_limit", int'(replay_limit), e_rpl);
    end
  end

  // ---- stimulus ----
  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || fail) && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic set_links(input bit rp, input bit pl, input bit du, input bit da, input logic [5:0] w);
    retrain_pending = rp; phy_link_up = pl; dl_up = du; dl_active = da; link_width = w;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 phy_rst in reset", int'(phy_rst), 1);
    chk("R1 train_en in reset", int'(train_en), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 core_rst idle", int'(core_rst), 1);
    chk("R1 ep_rst idle", int'(ep_rst), 1);
    chk("R1 done idle", int'(done), 0);
    chk("R1 attempt idle", int'(attempt), 0);
    chk("R1 replay idle", int'(replay_limit), 0);

    // x1, clean link
    tick_mode = 0; set_links(0, 1, 1, 1, 6'd1);
    pulse_start(); wait_end();
    chk("R5 done x1", int'(done), 1);
    chk("R6 single attempt", int'(attempt), 1);
    chk("R7 x1 limit", int'(replay_limit), 1677);

    // x2, retrain never clears, sparse ticks
    tick_mode = 1; set_links(1, 1, 1, 1, 6'd2);
    pulse_start(); wait_end();
    chk("R3 retrain timeout tolerated", int'(done), 1);
    chk("R7 x2 limit", int'(replay_limit), 867);

    // x4, no ticks first: timing must freeze
    tick_mode = 2; set_links(0, 1, 1, 1, 6'd4);
    pulse_start();
    repeat (30) @(negedge clk);
    chk("R9 core_rst frozen", int'(core_rst), 1);
    chk("R9 ep_rst frozen", int'(ep_rst), 1);
    tick_mode = 0; wait_end();
    chk("R7 x4 limit", int'(replay_limit), 462);

    // x8 with a start while busy
    set_links(0, 1, 1, 1, 6'd8);
    pulse_start();
    repeat (3) @(negedge clk);
    pulse_start();
    wait_end();
    chk("R8 busy start ignored", int'(attempt), 1);
    chk("R7 x8 limit", int'(replay_limit), 258);

    // other width code
    set_links(0, 1, 1, 1, 6'd16);
    pulse_start(); wait_end();
    chk("R7 other width", int'(replay_limit), 1677);

    // PHY link never comes up
    set_links(0, 0, 1, 1, 6'd1);
    pulse_start(); wait_end();
    chk("R4 fail on phy timeout", int'(fail), 1);
    chk("R6 all tries used", int'(attempt), P_TRIES);
    chk("R6 phy_rst held on fail", int'(phy_rst), 1);
    chk("R8 no done with fail", int'(done), 0);

    // data link never active
    set_links(0, 1, 1, 0, 6'd1);
    pulse_start(); wait_end();
    chk("R5 fail on dl inactive", int'(fail), 1);

    // recovers on the second attempt
    set_links(0, 1, 1, 0, 6'd2);
    pulse_start();
    chk("R8 fail cleared by start", int'(fail), 0);
    while (attempt != 2'd2 && !fail) @(negedge clk);
    dl_active = 1'b1;
    wait_end();
    chk("R6 success on retry", int'(attempt), 2);
    chk("R5 done after retry", int'(done), 1);
    link_width = 6'd4;
    repeat (10) @(negedge clk);
    chk("R7 limit held in done", int'(replay_limit), 867);

    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end
endmodule